// File: doc/BRIEF.md
# Seven-Bit PWM Generator with Full-On Code

This block turns a duty code into a single-bit pulse-width-modulated waveform. Each period is divided into 128 equal slots. A code from 1 to 126 drives the pin high for that many slots at the start of the period and low for the rest. Code 0 keeps the pin low. Code 127 is not treated as 127/128: it keeps the pin high for the whole period, so a 127/128 duty never appears.

A 5-bit frequency select sets the period. With a select value of N, the slot counter advances once every N clock cycles, so one period lasts 128 × N clock cycles. Value 1 gives the fastest rate. Value 0 is invalid and stops the generator.

New duty and select values are taken only when a period ends. A fade sequencer or any other controller can change the inputs at any time without producing a shortened or glitched pulse. The pin is driven straight from a flop.

Top module: `pwm7_gen`

## Requirements
- R1: For a duty code D from 1 to 126 and select N, each period starts with D × N high cycles followed by (128 − D) × N low cycles.
- R2: Duty code 0 keeps the output low for every cycle of the period.
- R3: Duty code 127 (all ones) keeps the output high for every cycle of the period.
- R4: With a select value N from 1 to 31, one period lasts exactly 128 × N clock cycles.
- R5: When the select value is 0, the output is low from the next cycle on and the counters stay cleared. A later nonzero select starts a fresh period.
- R6: When the enable is low, the output is low from the next cycle on. Raising the enable again starts a fresh period from slot 0.
- R7: A change of the duty code or of the select value during a period takes effect only at the next period boundary.
- R8: The output is registered. In the first cycle after the clock edge that starts a run, the output is low. Slot s appears on the pin one cycle after the counter holds s.
- R9: While reset is asserted, and right after it is released, the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable |
| duty_code | input | 7 | Duty code (0 = off, 127 = full on) |
| freq_sel | input | 5 | Period select N; period is 128 × N cycles; 0 is invalid |
| pwm_out | output | 1 | PWM output |

## Verification
At the fastest rate, every one of the 128 duty codes is run back to back. This separates the ordinary proportional codes from the two special codes, 0 and 127. It also shows that each new code waits for the period boundary.

A second pass steps the select value through 1 to 31, with duty codes spread over the range. A wrong prescaler divide, or a select change that takes effect before the boundary, moves the compared edges.

Separate patterns cover the following cases:
- dropping the enable in the middle of a period,
- selecting the invalid value 0,
- the restart after each of these, which must begin from slot 0.

// File: rtl/pwm7_pkg.sv
package pwm7_pkg;

   // Run phase of the generator
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } pwm_phase_e;

   // Largest supported code width
   localparam int unsigned PWM_MAX_DUTY_W = 12;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int unsigned SEL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [SEL_W-1:0] div,
   output logic             tick
);

   logic [SEL_W-1:0] cnt_q;
   logic [SEL_W-1:0] last_val;

   assign last_val = div - 1'b1;
   assign tick     = (cnt_q == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4: while counting, the divider is nonzero and the count stays below it
   a_r4_presc_bound : assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (div != '0 && cnt_q < div));

endmodule

// File: rtl/pwm_slot_ctr.sv
module pwm_slot_ctr #(
   parameter int unsigned DUTY_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick,
   output logic [DUTY_W-1:0] slot,
   output logic              wrap
);

   localparam logic [DUTY_W-1:0] SLOT_LAST = '1;

   logic [DUTY_W-1:0] slot_q;

   assign slot = slot_q;
   assign wrap = !clr && tick && (slot_q == SLOT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (clr) begin
         slot_q <= '0;
      end else if (tick) begin
         slot_q <= slot_q + 1'b1;
      end
   end

   // R4: a tick away from the last slot moves the counter up by exactly one
   a_r4_slot_step : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && tick && !wrap) |=> (slot_q == $past(slot_q) + 1'b1));

   // R4: without a tick the slot is held
   a_r4_slot_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !tick) |=> $stable(slot_q));

endmodule

// File: rtl/pwm_level_cmp.sv
module pwm_level_cmp #(
   parameter int unsigned DUTY_W  = 7,
   parameter bit          TOP_FULL = 1'b1
) (
   input  logic [DUTY_W-1:0] slot,
   input  logic [DUTY_W-1:0] duty,
   output logic              level
);

   localparam logic [DUTY_W-1:0] CODE_TOP = '1;

   logic below;

   assign below = (slot < duty);

   generate
      if (TOP_FULL) begin : g_full_on
         // the top code means constant high
         assign level = (duty == CODE_TOP) ? 1'b1 : below;
      end else begin : g_linear
         assign level = below;
      end
   endgenerate

endmodule

// File: rtl/pwm7_gen.sv
module pwm7_gen
   import pwm7_pkg::*;
#(
   parameter int unsigned DUTY_W   = 7,
   parameter int unsigned SEL_W    = 5,
   parameter bit          TOP_FULL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [DUTY_W-1:0] duty_code,
   input  logic [SEL_W-1:0]  freq_sel,
   output logic              pwm_out
);

   localparam logic [DUTY_W-1:0] CODE_TOP = '1;

   // elaboration-time parameter checks
   generate
      if (DUTY_W < 2 || DUTY_W > PWM_MAX_DUTY_W) begin : g_bad_duty_w
         $error("pwm7_gen: DUTY_W out of range");
      end
      if (SEL_W < 1 || SEL_W > 16) begin : g_bad_sel_w
         $error("pwm7_gen: SEL_W out of range");
      end
   endgenerate

   pwm_phase_e        phase_q;
   logic [SEL_W-1:0]  act_sel_q;
   logic [DUTY_W-1:0] act_duty_q;
   logic              out_q;

   logic              run_ok;
   logic              running;
   logic              cnt_clr;
   logic              tick;
   logic              wrap;
   logic              load;
   logic              level;
   logic [DUTY_W-1:0] slot;

   assign run_ok  = en && (freq_sel != '0);
   assign running = (phase_q == PH_RUN);
   assign cnt_clr = !run_ok || !running;
   assign load    = run_ok && (!running || wrap);

   pwm_prescaler #(
      .SEL_W (SEL_W)
   ) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .div   (act_sel_q),
      .tick  (tick)
   );

   pwm_slot_ctr #(
      .DUTY_W (DUTY_W)
   ) u_slots (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .tick  (tick),
      .slot  (slot),
      .wrap  (wrap)
   );

   pwm_level_cmp #(
      .DUTY_W   (DUTY_W),
      .TOP_FULL (TOP_FULL)
   ) u_cmp (
      .slot  (slot),
      .duty  (act_duty_q),
      .level (level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
      end else begin
         phase_q <= run_ok ? PH_RUN : PH_IDLE;
      end
   end

   // duty and divider are captured at start and at each period boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_sel_q  <= '0;
         act_duty_q <= '0;
      end else if (load) begin
         act_sel_q  <= freq_sel;
         act_duty_q <= duty_code;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0;
      end else begin
         out_q <= run_ok && running && level;
      end
   end

   assign pwm_out = out_q;

   // R5 and R6: an invalid select or a low enable forces the pin low next cycle
   a_r6_idle_low : assert property (@(posedge clk) disable iff (!rst_n)
      !run_ok |=> !pwm_out);

   // R7: the captured settings hold between boundaries
   a_r7_hold_cfg : assert property (@(posedge clk) disable iff (!rst_n)
      (running && run_ok && !wrap) |=> ($stable(act_duty_q) && $stable(act_sel_q)));

   // R2: code zero never drives high
   a_r2_zero_low : assert property (@(posedge clk) disable iff (!rst_n)
      (act_duty_q == '0) |=> !pwm_out);

   // R3: the top code drives high on every running cycle
   a_r3_full_on : assert property (@(posedge clk) disable iff (!rst_n)
      (TOP_FULL && run_ok && running && act_duty_q == CODE_TOP) |=> pwm_out);

   // R8: the first edge of a run still shows a low pin
   a_r8_start_low : assert property (@(posedge clk) disable iff (!rst_n)
      (run_ok && !running) |=> !pwm_out);

endmodule

// File: tb/test_pwm7_gen.sv
`timescale 1ns/1ps
module test_pwm7_gen;

   logic       clk;
   logic       rst_n;
   logic       en;
   logic [6:0] duty_code;
   logic [4:0] freq_sel;
   logic       pwm_out;

   int n_cmp  = 0;
   int n_fail = 0;

   pwm7_gen i_pwm7_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .duty_code (duty_code),
      .freq_sel  (freq_sel),
      .pwm_out   (pwm_out)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   task automatic check(input logic got, input logic exp, input string req);
      n_cmp++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: pwm_out=%0b expected %0b at %0t", req, got, exp, $time);
      end
   endtask

   // expected pin level for cycle i (1-based) of a period with select s and duty d
   function automatic logic exp_lvl(input int i, input int s, input int d);
      if (d == 127) return 1'b1;
      return (((i - 1) / s) < d);
   endfunction

   function automatic string req_of(input int d);
      if (d == 0)   return "R2";
      if (d == 127) return "R3";
      return "R1";
   endfunction

   // called at a negedge while idle: starts a run, R8 first cycle low
   task automatic start_run(input int s, input int d);
      en        = 1'b1;
      freq_sel  = 5'(s);
      duty_code = 7'(d);
      @(negedge clk);
      check(pwm_out, 1'b0, "R8");
   endtask

   // one full period; the next settings are applied on cycle 3, so they must
   // wait for the boundary (R7) while the period length follows s (R4)
   task automatic run_period(input int s, input int d, input int ns, input int nd);
      for (int i = 1; i <= 128 * s; i++) begin
         @(negedge clk);
         if (i == 3) begin
            freq_sel  = 5'(ns);
            duty_code = 7'(nd);
         end
         check(pwm_out, exp_lvl(i, s, d), (s > 1) ? "R4" : req_of(d));
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      en        = 1'b0;
      duty_code = 7'd64;
      freq_sel  = 5'd1;
      repeat (3) @(negedge clk);
      check(pwm_out, 1'b0, "R9");
      rst_n = 1'b1;
      @(negedge clk);
      check(pwm_out, 1'b0, "R9");

      // every duty code at the fastest rate (R1 R2 R3 R7)
      start_run(1, 0);
      for (int d = 0; d < 128; d++) begin
         run_period(1, d, 1, (d + 1) % 128);
      end

      // every select value with a spread of duties (R4 R7)
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      start_run(1, 5);
      run_period(1, 5, 1, 17);
      for (int s = 1; s <= 31; s++) begin
         run_period(s, (s == 1) ? 17 : (s * 37) % 128,
                    (s == 31) ? 31 : s + 1, ((s + 1) * 37) % 128);
      end

      // enable drops mid-period (R6)
      for (int i = 0; i < 40; i++) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check(pwm_out, 1'b0, "R6");
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         check(pwm_out, 1'b0, "R6");
      end
      start_run(2, 100);
      run_period(2, 100, 2, 100);

      // invalid select value zero (R5)
      for (int i = 0; i < 30; i++) @(negedge clk);
      freq_sel = 5'd0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         check(pwm_out, 1'b0, "R5");
      end
      start_run(3, 127);
      run_period(3, 127, 3, 1);
      run_period(3, 1, 3, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

endmodule